// File: doc/BRIEF.md
# One-Shot Display FIFO Flow Controller

This block governs how pixel words move from a composition channel into the output FIFO that feeds a display formatter. Software arms an update with an enable pulse. The channel then streams words into the FIFO, and the formatter pulls them out once the FIFO holds at least a watermark's worth. The update ends in one of three ways: a tearing-effect (TE) pulse from the panel in one-shot mode, a software sync trigger, or a software disable. After the update ends, the FIFO is emptied, and only then does the controller report itself idle.

The controller is a three-state machine. In IDLE, intake is closed and the FIFO is empty. In FLOW, intake is open. In DRAIN, intake is closed and the formatter takes whatever is left. The transitions are:
- ARM: IDLE to FLOW, on enable.
- STOP_TE: FLOW to DRAIN, when a TE pulse in one-shot mode brings the active-flow count to zero.
- STOP_SYNC: FLOW to DRAIN, on a sync trigger.
- STOP_SW: FLOW to DRAIN, on a software disable.
- REARM: DRAIN to FLOW, on enable.
- DRAINED: DRAIN to IDLE, once the FIFO is empty.

The watermark comes from the configured line width, capped according to the output mode. A drain that takes too long raises a sticky timeout. Three raw interrupt bits are gated by a mask:
- bit 0: TE stop
- bit 1: drained
- bit 2: drain timeout

Software handover follows a fixed sequence. If the empty flag is clear when software takes over, it arms the flow, issues a sync trigger, disables, and then polls the flow-enable readback until it falls. The same sequence sends a single frame when no TE synchronisation is used.

Top module: `oneshot_flow_ctrl`

## Requirements
- R1: After reset the block is in IDLE: `flow_en_rd`=0, `active_cnt`=0, `fifo_level`=0, `fifo_empty`=1, `irq_raw`=0, `irq`=0.
- R2: A channel word is accepted (`chan_ready`=1) only in FLOW and only while `fifo_level` < DEPTH. In IDLE and DRAIN, `chan_valid` leaves the level unchanged.
- R3: `watermark` equals min(`cfg_line_width`, VID_CAP) when `cfg_video_mode`=1, and min(`cfg_line_width`, CMD_CAP) when it is 0. The defaults are VID_CAP=128 and CMD_CAP=48, with a FIFO DEPTH of 640.
- R4: A formatter pull is granted (`fmt_valid`=1) in FLOW only if `fifo_level` >= `watermark`. In DRAIN it is granted whenever the FIFO is non-empty. Each grant removes one word at the next edge.
- R5: With `cfg_oneshot`=1, each enable pulse raises `active_cnt` by one, saturating at its maximum, and each `te_pulse` lowers it by one if it is non-zero. A decrement to zero in FLOW (STOP_TE) moves to DRAIN and sets `irq_raw` bit 0. With `cfg_oneshot`=0, enable leaves the count unchanged and TE has no effect.
- R6: A `sw_sync` pulse in FLOW closes intake and moves to DRAIN (STOP_SYNC).
- R7: `sw_disable` forces `active_cnt` to 0 at the next edge. In FLOW it moves to DRAIN (STOP_SW). It takes priority over an `sw_enable` in the same cycle.
- R8: `flow_en_rd` stays 1 throughout DRAIN, including the cycle in which `fifo_level` first reads 0. It reads 0 from the next edge (DRAINED), and that same edge sets `irq_raw` bit 1.
- R9: If DRAIN lasts DRAIN_TIMEOUT consecutive cycles with the FIFO non-empty, `irq_raw` bit 2 sets at the DRAIN_TIMEOUT-th edge after entry. It then stays set until cleared.
- R10: `irq_status` = `irq_raw` AND `irq_mask`, and `irq` is the OR of `irq_status`. Writing 1 on an `irq_clr` bit clears that raw bit at the next edge. A set in the same cycle wins.
- R11: `fifo_empty` is 1 exactly when `fifo_level` is 0, and `fifo_level` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_oneshot | input | 1 | TE-terminated one-shot mode |
| cfg_video_mode | input | 1 | 1: video output cap, 0: command output cap |
| cfg_line_width | input | LW_W | Pixels per line |
| sw_enable | input | 1 | Arm-flow pulse |
| sw_disable | input | 1 | Software stop pulse |
| sw_sync | input | 1 | Software sync trigger pulse |
| te_pulse | input | 1 | Tearing-effect event |
| chan_valid | input | 1 | Channel offers a word |
| chan_ready | output | 1 | Word accepted this cycle |
| fmt_pull | input | 1 | Formatter requests a word |
| fmt_valid | output | 1 | Pull granted this cycle |
| fifo_level | output | LVL_W | Words held in the FIFO |
| fifo_empty | output | 1 | FIFO empty flag |
| flow_en_rd | output | 1 | Flow-enable readback |
| watermark | output | LVL_W | Effective watermark |
| active_cnt | output | CNT_W | Active-flow count |
| irq_mask | input | 3 | Interrupt mask |
| irq_clr | input | 3 | Write-1-to-clear of raw bits |
| irq_raw | output | 3 | Raw interrupt status |
| irq_status | output | 3 | Masked interrupt status |
| irq | output | 1 | Interrupt line |

## Verification
A wrong state register shows up within one cycle at `chan_ready` and `flow_en_rd`. Intake either opens in IDLE or DRAIN, or stays closed in FLOW. A corrupted active-flow count shows on `active_cnt` at the next edge. It also shows at the TE pulse that should end the update, because the STOP_TE transition comes one TE too early or too late. Drain tracking is checked at the exact edge where `flow_en_rd` falls and at the exact edge where the timeout bit rises, so an off-by-one in either counter is visible on the very cycle it occurs.

// File: rtl/flow_ctrl_pkg.sv
package flow_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLOW  = 2'd1,
        ST_DRAIN = 2'd2
    } flow_state_e;

    localparam int IRQ_W       = 3;
    localparam int IRQ_TE_STOP = 0;
    localparam int IRQ_DRAINED = 1;
    localparam int IRQ_TIMEOUT = 2;
endpackage

// File: rtl/flow_wmark_calc.sv
module flow_wmark_calc #(
    parameter int LW_W    = 12,
    parameter int LVL_W   = 10,
    parameter int VID_CAP = 128,
    parameter int CMD_CAP = 48
) (
    input  logic             video_mode,
    input  logic [LW_W-1:0]  line_width,
    output logic [LVL_W-1:0] wmark
);
    localparam logic [31:0] VCAP = 32'(VID_CAP);
    localparam logic [31:0] CCAP = 32'(CMD_CAP);

    logic [31:0] width32;
    logic [31:0] cap32;
    logic [31:0] sel32;

    always_comb begin
        width32 = 32'(line_width);
        cap32   = video_mode ? VCAP : CCAP;
        sel32   = (width32 > cap32) ? cap32 : width32;
        wmark   = LVL_W'(sel32);
    end
endmodule

// File: rtl/flow_fifo_level.sv
module flow_fifo_level #(
    parameter int DEPTH = 640,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             full
);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic [LVL_W-1:0] level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    assign level = level_q;
    assign empty = (level_q == '0);
    assign full  = (level_q == LVL_MAX);
endmodule

// File: rtl/flow_ctrl_fsm.sv
module flow_ctrl_fsm
    import flow_ctrl_pkg::*;
#(
    parameter int CNT_W         = 4,
    parameter int DRAIN_TIMEOUT = 100000,
    parameter int TMO_W         = $clog2(DRAIN_TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oneshot,
    input  logic             sw_enable,
    input  logic             sw_disable,
    input  logic             sw_sync,
    input  logic             te_pulse,
    input  logic             fifo_empty,
    output flow_state_e      state,
    output logic [CNT_W-1:0] active_cnt,
    output logic             ev_te_stop,
    output logic             ev_drained,
    output logic             ev_timeout
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [TMO_W-1:0] TMO_LIM  = TMO_W'(DRAIN_TIMEOUT);
    localparam logic [TMO_W-1:0] TMO_FIRE = TMO_W'(DRAIN_TIMEOUT - 1);

    flow_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TMO_W-1:0] tmo_q, tmo_d;
    logic             arm, te_take, inc, dec;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmo_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tmo_q   <= tmo_d;
        end
    end

    // next-state and output process
    always_comb begin
        arm     = sw_enable && !sw_disable;
        te_take = oneshot && te_pulse && (cnt_q != '0);
        inc     = sw_enable && oneshot && (cnt_q != CNT_MAX);
        dec     = te_take;

        state_d    = state_q;
        ev_te_stop = 1'b0;
        ev_drained = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (arm) state_d = ST_FLOW;                      // ARM
            end
            ST_FLOW: begin
                if (sw_disable || sw_sync) begin
                    state_d = ST_DRAIN;                          // STOP_SW / STOP_SYNC
                end else if (te_take && (cnt_q == CNT_ONE) && !sw_enable) begin
                    state_d    = ST_DRAIN;                       // STOP_TE
                    ev_te_stop = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (arm) begin
                    state_d = ST_FLOW;                           // REARM
                end else if (fifo_empty) begin
                    state_d    = ST_IDLE;                        // DRAINED
                    ev_drained = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (sw_disable) begin
            cnt_d = '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt_d = cnt_q + 1'b1;
                2'b01:   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end

        if ((state_q == ST_DRAIN) && !fifo_empty) begin
            tmo_d = (tmo_q == TMO_LIM) ? tmo_q : tmo_q + 1'b1;
        end else begin
            tmo_d = '0;
        end
        ev_timeout = (state_q == ST_DRAIN) && !fifo_empty && (tmo_q == TMO_FIRE);

        state      = state_q;
        active_cnt = cnt_q;
    end
endmodule

// File: rtl/flow_irq_regs.sv
module flow_irq_regs #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] raw,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr) | set;
    end

    assign raw    = raw_q;
    assign status = raw_q & mask;
    assign irq    = |status;
endmodule

// File: rtl/oneshot_flow_ctrl.sv
module oneshot_flow_ctrl
    import flow_ctrl_pkg::*;
#(
    parameter int DEPTH         = 640,
    parameter int LW_W          = 12,
    parameter int VID_CAP       = 128,
    parameter int CMD_CAP       = 48,
    parameter int CNT_W         = 4,
    parameter int DRAIN_TIMEOUT = 100000,
    parameter int LVL_W         = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_oneshot,
    input  logic             cfg_video_mode,
    input  logic [LW_W-1:0]  cfg_line_width,
    input  logic             sw_enable,
    input  logic             sw_disable,
    input  logic             sw_sync,
    input  logic             te_pulse,
    input  logic             chan_valid,
    output logic             chan_ready,
    input  logic             fmt_pull,
    output logic             fmt_valid,
    output logic [LVL_W-1:0] fifo_level,
    output logic             fifo_empty,
    output logic             flow_en_rd,
    output logic [LVL_W-1:0] watermark,
    output logic [CNT_W-1:0] active_cnt,
    input  logic [2:0]       irq_mask,
    input  logic [2:0]       irq_clr,
    output logic [2:0]       irq_raw,
    output logic [2:0]       irq_status,
    output logic             irq
);
    flow_state_e      state;
    logic             full, push, pop;
    logic             ev_te_stop, ev_drained, ev_timeout;
    logic [IRQ_W-1:0] irq_set;

    flow_wmark_calc #(
        .LW_W(LW_W), .LVL_W(LVL_W), .VID_CAP(VID_CAP), .CMD_CAP(CMD_CAP)
    ) u_wmark (
        .video_mode(cfg_video_mode),
        .line_width(cfg_line_width),
        .wmark     (watermark)
    );

    flow_fifo_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .pop  (pop),
        .level(fifo_level),
        .empty(fifo_empty),
        .full (full)
    );

    flow_ctrl_fsm #(.CNT_W(CNT_W), .DRAIN_TIMEOUT(DRAIN_TIMEOUT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .oneshot   (cfg_oneshot),
        .sw_enable (sw_enable),
        .sw_disable(sw_disable),
        .sw_sync   (sw_sync),
        .te_pulse  (te_pulse),
        .fifo_empty(fifo_empty),
        .state     (state),
        .active_cnt(active_cnt),
        .ev_te_stop(ev_te_stop),
        .ev_drained(ev_drained),
        .ev_timeout(ev_timeout)
    );

    always_comb begin
        irq_set              = '0;
        irq_set[IRQ_TE_STOP] = ev_te_stop;
        irq_set[IRQ_DRAINED] = ev_drained;
        irq_set[IRQ_TIMEOUT] = ev_timeout;
    end

    flow_irq_regs #(.N(IRQ_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .clr   (irq_clr),
        .mask  (irq_mask),
        .raw   (irq_raw),
        .status(irq_status),
        .irq   (irq)
    );

    assign chan_ready = (state == ST_FLOW) && !full;
    assign push       = chan_valid && chan_ready;
    assign fmt_valid  = fmt_pull && !fifo_empty &&
                        ((state != ST_FLOW) || (fifo_level >= watermark));
    assign pop        = fmt_valid;
    assign flow_en_rd = (state != ST_IDLE);
endmodule

// File: rtl/oneshot_flow_ctrl_chk.sv
module oneshot_flow_ctrl_chk #(
    parameter int DEPTH = 640,
    parameter int CNT_W = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_oneshot,
    input logic             sw_enable,
    input logic             sw_disable,
    input logic             te_pulse,
    input logic             chan_valid,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_empty,
    input logic             flow_en_rd,
    input logic [CNT_W-1:0] active_cnt,
    input logic [2:0]       irq_raw,
    input logic [2:0]       irq_clr
);
    // R11
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    // R2
    push_needs_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level > $past(fifo_level)) |-> $past(chan_valid && flow_en_rd));

    // R8
    flow_falls_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flow_en_rd) |-> $past(fifo_empty));

    // R7
    disable_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_disable |=> (active_cnt == '0));

    // R5
    te_decrements_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oneshot && te_pulse && !sw_enable && !sw_disable && active_cnt != '0)
        |=> (active_cnt == CNT_W'($past(active_cnt) - 1'b1)));

    // R9
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw[2] && !irq_clr[2]) |=> irq_raw[2]);
endmodule

bind oneshot_flow_ctrl oneshot_flow_ctrl_chk #(
    .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_oneshot(cfg_oneshot),
    .sw_enable  (sw_enable),
    .sw_disable (sw_disable),
    .te_pulse   (te_pulse),
    .chan_valid (chan_valid),
    .fifo_level (fifo_level),
    .fifo_empty (fifo_empty),
    .flow_en_rd (flow_en_rd),
    .active_cnt (active_cnt),
    .irq_raw    (irq_raw),
    .irq_clr    (irq_clr)
);

// File: tb/oneshot_flow_ctrl_test.sv
`timescale 1ns/1ps
module oneshot_flow_ctrl_test;
    localparam int DEPTH = 40;
    localparam int LW_W  = 8;
    localparam int VCAP  = 16;
    localparam int CCAP  = 6;
    localparam int CNT_W = 3;
    localparam int TMO   = 20;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_oneshot = 1'b0, cfg_video_mode = 1'b0;
    logic [LW_W-1:0]  cfg_line_width = 8'd10;
    logic             sw_enable = 1'b0, sw_disable = 1'b0, sw_sync = 1'b0, te_pulse = 1'b0;
    logic             chan_valid = 1'b0, fmt_pull = 1'b0;
    logic             chan_ready, fmt_valid, fifo_empty, flow_en_rd, irq;
    logic [LVL_W-1:0] fifo_level, watermark;
    logic [CNT_W-1:0] active_cnt;
    logic [2:0]       irq_mask = 3'b000, irq_clr = 3'b000, irq_raw, irq_status;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    oneshot_flow_ctrl #(
        .DEPTH(DEPTH), .LW_W(LW_W), .VID_CAP(VCAP), .CMD_CAP(CCAP),
        .CNT_W(CNT_W), .DRAIN_TIMEOUT(TMO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_oneshot(cfg_oneshot),
        .cfg_video_mode(cfg_video_mode), .cfg_line_width(cfg_line_width),
        .sw_enable(sw_enable), .sw_disable(sw_disable), .sw_sync(sw_sync),
        .te_pulse(te_pulse), .chan_valid(chan_valid), .chan_ready(chan_ready),
        .fmt_pull(fmt_pull), .fmt_valid(fmt_valid), .fifo_level(fifo_level),
        .fifo_empty(fifo_empty), .flow_en_rd(flow_en_rd), .watermark(watermark),
        .active_cnt(active_cnt), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .irq_raw(irq_raw), .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_en();  sw_enable = 1'b1;  step(); sw_enable = 1'b0;  endtask
    task automatic pulse_te();  te_pulse = 1'b1;   step(); te_pulse = 1'b0;   endtask
    task automatic pulse_dis(); sw_disable = 1'b1; step(); sw_disable = 1'b0; endtask
    task automatic pulse_sync(); sw_sync = 1'b1;   step(); sw_sync = 1'b0;    endtask
    task automatic clr_all();   irq_clr = 3'b111;  step(); irq_clr = 3'b000;  endtask

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 flow_en_rd", flow_en_rd, 0);
        chk("R1 active_cnt", active_cnt, 0);
        chk("R1 fifo_level", fifo_level, 0);
        chk("R1 fifo_empty", fifo_empty, 1);
        chk("R1 irq_raw", irq_raw, 0);
        chk("R1 irq", irq, 0);

        // R3 watermark sweep over both modes and every width
        for (int m = 0; m < 2; m++) begin
            for (int w = 0; w < 256; w++) begin
                int cap;
                cap = (m == 1) ? VCAP : CCAP;
                cfg_video_mode = m[0];
                cfg_line_width = w[7:0];
                #0.2;
                chk("R3 watermark", watermark, (w > cap) ? cap : w);
            end
        end
        cfg_video_mode = 1'b0;
        cfg_line_width = 8'd10;  // command mode: watermark 6
        #0.2;

        // R2 intake closed in IDLE
        chan_valid = 1'b1;
        #0.2;
        chk("R2 ready in IDLE", chan_ready, 0);
        repeat (3) step();
        chan_valid = 1'b0;
        chk("R2 level in IDLE", fifo_level, 0);

        // R5 one-shot count up
        cfg_oneshot = 1'b1;
        repeat (3) pulse_en();
        chk("R5 count after 3 enables", active_cnt, 3);
        chk("R5 flow armed", flow_en_rd, 1);

        // R4 watermark gating in FLOW, one word at a time
        for (int k = 1; k <= 8; k++) begin
            chan_valid = 1'b1;
            step();
            chan_valid = 1'b0;
            chk("R2 level after push", fifo_level, k);
            fmt_pull = 1'b1;
            #0.4;
            chk("R4 grant in FLOW", fmt_valid, (k >= CCAP) ? 1 : 0);
            fmt_pull = 1'b0;
            #0.4;
        end

        // R5 TE countdown
        pulse_te();
        chk("R5 count after TE", active_cnt, 2);
        pulse_te();
        chk("R5 count after TE", active_cnt, 1);
        chk("R5 still flowing", chan_ready, 1);
        pulse_te();
        chk("R5 count zero", active_cnt, 0);
        chk("R5 intake closed", chan_ready, 0);
        chk("R8 readback held", flow_en_rd, 1);
        chk("R5 te stop irq", irq_raw, 3'b001);

        // R4 drain below watermark, R8 exact fall
        fmt_pull = 1'b1;
        repeat (5) step();
        chk("R4 level mid drain", fifo_level, 3);
        chk("R4 grant in DRAIN", fmt_valid, 1);
        repeat (3) step();
        chk("R11 empty", fifo_empty, 1);
        chk("R8 readback at empty", flow_en_rd, 1);
        step();
        fmt_pull = 1'b0;
        chk("R8 readback cleared", flow_en_rd, 0);
        chk("R8 drained irq", irq_raw, 3'b011);

        // R5 TE with zero count
        pulse_te();
        chk("R5 TE at zero", active_cnt, 0);

        // R10 write-1-clear
        clr_all();
        chk("R10 cleared", irq_raw, 0);

        // R5 TE ignored outside one-shot, R6 sync stop
        cfg_oneshot = 1'b0;
        pulse_en();
        chk("R5 no count in stream mode", active_cnt, 0);
        pulse_te();
        chk("R5 TE ignored flow", flow_en_rd, 1);
        chk("R5 TE ignored ready", chan_ready, 1);
        pulse_sync();
        chk("R6 sync closes intake", chan_ready, 0);
        chk("R6 sync readback", flow_en_rd, 1);
        step();
        chk("R6 drained after sync", flow_en_rd, 0);
        chk("R6 drained irq", irq_raw, 3'b010);
        clr_all();

        // R7 disable priority, R9 timeout boundary
        cfg_oneshot = 1'b1;
        pulse_en();
        pulse_en();
        chk("R5 count 2", active_cnt, 2);
        chan_valid = 1'b1;
        repeat (3) step();
        chan_valid = 1'b0;
        chk("R2 level 3", fifo_level, 3);
        sw_enable = 1'b1;
        sw_disable = 1'b1;
        step();
        sw_enable = 1'b0;
        sw_disable = 1'b0;
        chk("R7 count zero", active_cnt, 0);
        chk("R7 intake closed", chan_ready, 0);
        chk("R7 readback held", flow_en_rd, 1);
        repeat (TMO - 1) step();
        chk("R9 not yet", irq_raw[2], 0);
        step();
        chk("R9 timeout set", irq_raw[2], 1);
        chk("R10 masked off irq", irq, 0);
        chk("R10 masked off status", irq_status, 0);
        irq_mask = 3'b100;
        #0.2;
        chk("R10 mask on irq", irq, 1);
        chk("R10 mask on status", irq_status, 3'b100);
        fmt_pull = 1'b1;
        repeat (3) step();
        step();
        fmt_pull = 1'b0;
        chk("R8 drained late", flow_en_rd, 0);
        chk("R9 sticky", irq_raw, 3'b110);
        irq_clr = 3'b100;
        step();
        irq_clr = 3'b000;
        chk("R10 single clear", irq_raw, 3'b010);
        clr_all();
        irq_mask = 3'b000;

        // R11 full FIFO
        cfg_oneshot = 1'b0;
        pulse_en();
        chan_valid = 1'b1;
        repeat (DEPTH + 5) step();
        chan_valid = 1'b0;
        chk("R11 level capped", fifo_level, DEPTH);
        chk("R2 ready when full", chan_ready, 0);
        chk("R11 not empty", fifo_empty, 0);
        pulse_dis();
        fmt_pull = 1'b1;
        repeat (DEPTH) step();
        chk("R8 held at empty", flow_en_rd, 1);
        step();
        fmt_pull = 1'b0;
        chk("R8 cleared after full drain", flow_en_rd, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule